// File: doc/BRIEF.md
# Phase-Stepped Sine Table Oscillator

This block produces sampled sine waves by walking a read pointer around a 256-entry table that holds one full sine period. Each accepted sample tick adds a programmable step to the pointer. The pointer wraps past the last entry back to the start, so the step sets the output frequency. A step of `s` gives `s/256` cycles per tick.

The same pointer also drives three extra taps at fixed offsets into the table. The four registered outputs therefore give a sine, a cosine a quarter period ahead, and two further phases about one third and two thirds of a period ahead. Together with the sine, those two phases form a three-phase set.

The block updates only when the timer-derived tick strobe and the enable are both high. Samples are signed 16-bit fractions with a peak of half full scale.

Top module: `wavetable_osc`

## Requirements
- R1: While reset is asserted, and until the first accepted tick, the pointer and all four outputs are zero.
- R2: Table entry k holds round(16384 * sin(2*pi*k/256)) as a 16-bit two's-complement fraction in 1.15 format. Rounding is half away from zero.
- R3: An accepted tick is a clock edge with `tick` and `en` both high. On any other edge the pointer and all outputs keep their values.
- R4: On an accepted tick, every output loads the table entry at the current pointer plus its offset, and the pointer becomes (pointer + `step`) mod 256. The first accepted tick after reset therefore presents index 0 plus each offset.
- R5: `cos_o` reads the table at (pointer + 64) mod 256.
- R6: `sin_o` is phase A at offset 0. `phb_o` reads at (pointer + 85) mod 256 and `phc_o` at (pointer + 171) mod 256.
- R7: With `step` at 0, successive accepted ticks repeat the same output values.
- R8: No output magnitude ever exceeds 16384.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample strobe, one clock wide |
| en | input | 1 | Enable; ticks are ignored while low |
| step | input | 8 | Pointer increment per accepted tick |
| sin_o | output | 16 | Sine / phase A sample |
| cos_o | output | 16 | Cosine sample, a quarter period ahead |
| phb_o | output | 16 | Phase B sample, offset 85 |
| phc_o | output | 16 | Phase C sample, offset 171 |

## Verification
The assertions assume that `tick` and `en` are sampled on the clock edge only. They also assume that `step` is stable on an accepted edge, so that the pointer advance can be compared with the step value seen on that edge.

The stimulus changes every input on the falling clock edge, holds `tick` for a single cycle, and sweeps all 256 step values. Between accepted ticks it also applies ticks with `en` low and idle gaps.

// File: rtl/wavetable_osc.sv
module wavetable_osc #(
  parameter int DEPTH = 256,
  parameter int DW    = 16,
  parameter int AMP   = 16384
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 en,
  input  logic [$clog2(DEPTH)-1:0] step,
  output logic signed [DW-1:0] sin_o,
  output logic signed [DW-1:0] cos_o,
  output logic signed [DW-1:0] phb_o,
  output logic signed [DW-1:0] phc_o
);
  localparam int AW    = $clog2(DEPTH);
  localparam int OFF_Q = DEPTH / 4;
  localparam int OFF_B = (DEPTH + 1) / 3;
  localparam int OFF_C = (2 * DEPTH + 1) / 3;

  function automatic logic signed [DW-1:0] sine_at(int k);
    real r;
    r = real'(AMP) * $sin(2.0 * 3.14159265358979 * real'(k) / real'(DEPTH));
    if (r >= 0.0) return DW'($rtoi(r + 0.5));
    else          return DW'(-$rtoi(0.5 - r));
  endfunction

  logic signed [DW-1:0] rom [DEPTH];
  for (genvar k = 0; k < DEPTH; k++) begin : g_rom
    assign rom[k] = sine_at(k);
  end

  logic [AW-1:0] ptr;
  logic          go;
  logic [AW-1:0] ix_q, ix_b, ix_c;

  assign go   = tick && en;
  assign ix_q = ptr + AW'(OFF_Q);
  assign ix_b = ptr + AW'(OFF_B);
  assign ix_c = ptr + AW'(OFF_C);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr   <= '0;
      sin_o <= '0;
      cos_o <= '0;
      phb_o <= '0;
      phc_o <= '0;
    end else if (go) begin
      ptr   <= ptr + step;
      sin_o <= rom[ptr];
      cos_o <= rom[ix_q];
      phb_o <= rom[ix_b];
      phc_o <= rom[ix_c];
    end
  end

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> ($stable(sin_o) && $stable(cos_o) && $stable(phb_o) && $stable(phc_o)));

  assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> ptr == AW'($past(ptr) + $past(step)));

  assert_zero_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (go && step == '0) |=> $stable(ptr));

  assert_peak_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sin_o <= AMP) && (sin_o >= -AMP) && (cos_o <= AMP) && (cos_o >= -AMP) &&
    (phb_o <= AMP) && (phb_o >= -AMP) && (phc_o <= AMP) && (phc_o >= -AMP));
endmodule

// File: tb/sim_wavetable_osc.sv
module sim_wavetable_osc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic en = 1'b0;
  logic [7:0] step = '0;
  logic signed [15:0] sin_o, cos_o, phb_o, phc_o;

  int vectors = 0;
  int fails = 0;
  logic [7:0] mptr = '0;

  always #5 clk = ~clk;

  wavetable_osc u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .step(step),
                    .sin_o(sin_o), .cos_o(cos_o), .phb_o(phb_o), .phc_o(phc_o));

  function automatic int ref_sine(int k);
    real r;
    r = 16384.0 * $sin(2.0 * 3.14159265358979 * real'(k % 256) / 256.0);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(0.5 - r);
  endfunction

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_all(string req, int base);
    check({req, " sin"}, sin_o, ref_sine(base));
    check({req, " cos R5"}, cos_o, ref_sine(base + 64));
    check({req, " phb R6"}, phb_o, ref_sine(base + 85));
    check({req, " phc R6"}, phc_o, ref_sine(base + 171));
  endtask

  task automatic pulse(logic en_v);
    @(negedge clk);
    tick = 1'b1;
    en = en_v;
    @(negedge clk);
    tick = 1'b0;
    en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int held_s;
    repeat (3) @(negedge clk);
    check("R1 sin", sin_o, 0);
    check("R1 cos", cos_o, 0);
    check("R1 phb", phb_o, 0);
    check("R1 phc", phc_o, 0);
    rst_n = 1'b1;
    step = 8'd37;
    pulse(1'b0);
    check("R3 disabled tick", sin_o, 0);
    check("R1 pre-tick cos", cos_o, 0);
    pulse(1'b1);
    check_all("R4 first tick index 0", 0);
    mptr = 8'd37;
    for (int s = 0; s < 256; s++) begin
      step = 8'(s);
      for (int t = 0; t < 6; t++) begin
        pulse(1'b1);
        check_all("R2 R4 sweep", int'(mptr));
        mptr = mptr + 8'(s);
        check("R8 bound", ((sin_o <= 16384) && (sin_o >= -16384)) ? 1 : 0, 1);
      end
      held_s = sin_o;
      pulse(1'b0);
      check("R3 en low hold", sin_o, held_s);
      @(negedge clk);
      @(negedge clk);
      check("R3 idle hold", sin_o, held_s);
    end
    step = 8'd0;
    pulse(1'b1);
    held_s = sin_o;
    for (int t = 0; t < 4; t++) begin
      pulse(1'b1);
      check("R7 zero step", sin_o, held_s);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule